// File: doc/BRIEF.md
# Worker Result Join Tracker

This block gathers the results that a team of worker tasks sends back to one shared join record. When the last expected result arrives, it hands a successor task to the scheduler queue. A setup command opens the record. It carries the successor's codelet index, its argument count, the handle of its argument chunk and the number of results to wait for. After that, each worker sends one update: a slot index and a 64-bit value. The value is written into that slot of a 16-entry result store. A presence flag for the slot is set and an arrival counter is incremented.

All join state can be read on one packed 64-bit control word output. A combinational read port returns the stored results. When the arrival counter reaches the declared count, a task record (codelet index, 4-bit argument count, 64-bit argument handle) is presented on a valid/ready output. The block raises error pulses for:
- a second result for a slot that already holds one;
- a result for a slot beyond the declared count;
- a result that arrives while no collection is open.

It raises a reject pulse for a setup command that arrives at the wrong time or carries bad values.

Top module: `sync_join_tracker`

## Requirements
- R1: After reset, `task_valid`, `create_reject` and `upd_error` are 0 and `ctrl_word` reads all zero.
- R2: A setup command is accepted only when no collection is open and no task record is pending, with an item count of 1 to 16 and an argument count of 0 to 14. Any other setup raises `create_reject` for one cycle, starting the cycle after, and leaves `ctrl_word` unchanged.
- R3: An accepted setup loads the codelet index into `ctrl_word[63:48]`, the argument count into `[29:24]` and the item count into `[11:6]`. It clears the presence flags `[47:32]` and the arrival counter `[5:0]`. Bits `[31:30]` and `[23:12]` always read 0.
- R4: An update accepted while collecting, with index below the item count and its flag clear, has these effects from the next cycle: the value is stored in slot index (readable on `rd_data` with `rd_idx` = index), flag bit `32+index` is set and the arrival counter rises by one.
- R5: An update to a slot whose flag is already set raises `upd_error` the cycle after, and changes neither `ctrl_word` nor the stored slot.
- R6: An update whose index is not below the item count raises `upd_error` the cycle after and changes nothing.
- R7: The update that makes the arrival counter equal the item count raises `task_valid` the next cycle. The record carries the codelet index, the low 4 bits of the argument count and the argument handle. The completion is independent of arrival order.
- R8: When the argument count is 0, `task_handle` is all zero, whatever handle the setup carried.
- R9: While `task_valid` is high and `task_ready` is low, the record stays stable. After a cycle with both high, `task_valid` is 0.
- R10: After the record is emitted, the join fires no second time. Every later update raises `upd_error` and leaves `ctrl_word` and the slots unchanged until the next accepted setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| create_valid | input | 1 | Setup command strobe |
| create_code | input | 16 | Successor codelet index |
| create_args | input | 6 | Successor argument count |
| create_items | input | 6 | Number of results to wait for |
| create_handle | input | 64 | Handle of the successor's argument chunk |
| create_reject | output | 1 | Setup refused (one-cycle pulse) |
| upd_valid | input | 1 | Worker result strobe |
| upd_idx | input | 6 | Result slot index |
| upd_data | input | 64 | Result value |
| upd_error | output | 1 | Result refused (one-cycle pulse) |
| rd_idx | input | 4 | Result store read index |
| rd_data | output | 64 | Result store read data |
| ctrl_word | output | 64 | Packed join control word |
| task_valid | output | 1 | Task record available |
| task_ready | input | 1 | Scheduler queue accepts the record |
| task_code | output | 16 | Task record codelet index |
| task_args | output | 4 | Task record argument count |
| task_handle | output | 64 | Task record argument handle |

## Verification
The bench sweeps every item count from 1 to 16 under ascending, descending and evens-then-odds arrival orders, and injects duplicate and out-of-range results along the way. Three kinds of broken design are targeted:
- A design that counted arrivals without the presence flags would fire early on a duplicate.
- A design that compared the index against the store size instead of the declared count would accept stray slots.
- A design that compared the counter before the increment would fire one result late or one result early.

The bench also probes several timing corners:
- a setup command arriving during a collection or while the record is pending;
- a zero argument count, which must null the handle;
- a stalled scheduler queue, which must not let the record change;
- a late result after the join has fired, which must not fire it a second time.

// File: rtl/sjt_pkg.sv
package sjt_pkg;
  // Field width of every 6-bit count/index field of the control word
  localparam int FLD_W  = 6;
  localparam int FLAG_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_EMIT    = 2'd2,
    ST_DONE    = 2'd3
  } sjt_state_e;

  function automatic logic [63:0] pack_ctrl(
    input logic [15:0]       code,
    input logic [FLAG_W-1:0] flags,
    input logic [FLD_W-1:0]  args,
    input logic [FLD_W-1:0]  items,
    input logic [FLD_W-1:0]  cnt
  );
    return {code, flags, 2'b00, args, {FLD_W{1'b0}}, {FLD_W{1'b0}}, items, cnt};
  endfunction
endpackage

// File: rtl/sjt_slot_store.sv
module sjt_slot_store #(
  parameter int SLOTS  = 16,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 6,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  probe_idx,
  output logic              probe_hit,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  flags
);
  logic [DATA_W-1:0] slot_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_wr;
    logic flag_d;
    logic flag_q;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(s));

    always_comb begin
      flag_d = flag_q;
      if (clear)       flag_d = 1'b0;
      else if (hit_wr) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      slot_q[s] <= '0;
      else if (hit_wr) slot_q[s] <= wr_data;
    end

    assign flags[s] = flag_q;
  end

  always_comb begin
    probe_hit = 1'b0;
    if (probe_idx < IDX_W'(SLOTS)) probe_hit = flags[probe_idx[SLOT_W-1:0]];
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/sjt_ctrl.sv
module sjt_ctrl
  import sjt_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int CODE_W   = 16,
  parameter int DATA_W   = 64,
  parameter int MAX_ARGS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              create_valid,
  input  logic [CODE_W-1:0] create_code,
  input  logic [FLD_W-1:0]  create_args,
  input  logic [FLD_W-1:0]  create_items,
  input  logic [DATA_W-1:0] create_handle,
  input  logic              upd_valid,
  input  logic [FLD_W-1:0]  upd_idx,
  input  logic              slot_taken,
  input  logic              task_taken,
  output logic              create_ok,
  output logic              upd_ok,
  output logic              fire,
  output logic              create_reject,
  output logic              upd_error,
  output logic [CODE_W-1:0] code_q,
  output logic [FLD_W-1:0]  args_q,
  output logic [FLD_W-1:0]  items_q,
  output logic [FLD_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] handle_q
);
  sjt_state_e state_q, state_d;
  logic [FLD_W-1:0] cnt_d;
  logic             open_ok;
  logic             fields_ok;

  assign open_ok   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign fields_ok = (create_items != '0) && (create_items <= FLD_W'(SLOTS)) &&
                     (create_args <= FLD_W'(MAX_ARGS));
  assign create_ok = create_valid && open_ok && fields_ok;
  assign upd_ok    = upd_valid && (state_q == ST_COLLECT) &&
                     (upd_idx < items_q) && !slot_taken;
  assign fire      = upd_ok && ((cnt_q + FLD_W'(1)) == items_q);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (create_ok) begin
      state_d = ST_COLLECT;
      cnt_d   = '0;
    end else if (upd_ok) begin
      cnt_d = cnt_q + FLD_W'(1);
      if (fire) state_d = ST_EMIT;
    end else if ((state_q == ST_EMIT) && task_taken) begin
      state_d = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      cnt_q         <= '0;
      create_reject <= 1'b0;
      upd_error     <= 1'b0;
    end else begin
      state_q       <= state_d;
      cnt_q         <= cnt_d;
      create_reject <= create_valid && !create_ok;
      upd_error     <= upd_valid && !upd_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      args_q   <= '0;
      items_q  <= '0;
      handle_q <= '0;
    end else if (create_ok) begin
      code_q   <= create_code;
      args_q   <= create_args;
      items_q  <= create_items;
      handle_q <= create_handle;
    end
  end
endmodule

// File: rtl/sjt_task_out.sv
module sjt_task_out #(
  parameter int CODE_W = 16,
  parameter int TARG_W = 4,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic [TARG_W-1:0] args_in,
  input  logic [DATA_W-1:0] handle_in,
  input  logic              task_ready,
  output logic              task_valid,
  output logic [CODE_W-1:0] task_code,
  output logic [TARG_W-1:0] task_args,
  output logic [DATA_W-1:0] task_handle,
  output logic              taken
);
  logic valid_d;

  assign taken = task_valid && task_ready;

  always_comb begin
    valid_d = task_valid;
    if (load)       valid_d = 1'b1;
    else if (taken) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) task_valid <= 1'b0;
    else        task_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_code   <= '0;
      task_args   <= '0;
      task_handle <= '0;
    end else if (load) begin
      task_code   <= code_in;
      task_args   <= args_in;
      task_handle <= (args_in == '0) ? '0 : handle_in;
    end
  end
endmodule

// File: rtl/sync_join_tracker.sv
module sync_join_tracker
  import sjt_pkg::*;
#(
  parameter int SLOTS    = 16,
  parameter int CODE_W   = 16,
  parameter int DATA_W   = 64,
  parameter int MAX_ARGS = 14,
  parameter int TARG_W   = 4,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              create_valid,
  input  logic [CODE_W-1:0] create_code,
  input  logic [5:0]        create_args,
  input  logic [5:0]        create_items,
  input  logic [DATA_W-1:0] create_handle,
  output logic              create_reject,
  input  logic              upd_valid,
  input  logic [5:0]        upd_idx,
  input  logic [DATA_W-1:0] upd_data,
  output logic              upd_error,
  input  logic [SLOT_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [63:0]       ctrl_word,
  output logic              task_valid,
  input  logic              task_ready,
  output logic [CODE_W-1:0] task_code,
  output logic [TARG_W-1:0] task_args,
  output logic [DATA_W-1:0] task_handle
);
  logic              create_ok, upd_ok, fire, slot_taken, task_taken;
  logic [CODE_W-1:0] code_q;
  logic [FLD_W-1:0]  args_q, items_q, cnt_q;
  logic [DATA_W-1:0] handle_q;
  logic [SLOTS-1:0]  flags;

  sjt_ctrl #(.SLOTS(SLOTS), .CODE_W(CODE_W), .DATA_W(DATA_W), .MAX_ARGS(MAX_ARGS)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .create_valid(create_valid), .create_code(create_code), .create_args(create_args),
    .create_items(create_items), .create_handle(create_handle),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .slot_taken(slot_taken), .task_taken(task_taken),
    .create_ok(create_ok), .upd_ok(upd_ok), .fire(fire),
    .create_reject(create_reject), .upd_error(upd_error),
    .code_q(code_q), .args_q(args_q), .items_q(items_q), .cnt_q(cnt_q), .handle_q(handle_q)
  );

  sjt_slot_store #(.SLOTS(SLOTS), .DATA_W(DATA_W), .IDX_W(FLD_W)) store_i (
    .clk(clk), .rst_n(rst_n), .clear(create_ok),
    .wr_en(upd_ok), .wr_idx(upd_idx), .wr_data(upd_data),
    .probe_idx(upd_idx), .probe_hit(slot_taken),
    .rd_idx(rd_idx), .rd_data(rd_data), .flags(flags)
  );

  sjt_task_out #(.CODE_W(CODE_W), .TARG_W(TARG_W), .DATA_W(DATA_W)) out_i (
    .clk(clk), .rst_n(rst_n), .load(fire),
    .code_in(code_q), .args_in(args_q[TARG_W-1:0]), .handle_in(handle_q),
    .task_ready(task_ready), .task_valid(task_valid),
    .task_code(task_code), .task_args(task_args), .task_handle(task_handle),
    .taken(task_taken)
  );

  assign ctrl_word = pack_ctrl(16'(code_q), FLAG_W'(flags), args_q, items_q, cnt_q);
endmodule

// File: rtl/sjt_chk.sv
module sjt_chk #(
  parameter int CODE_W = 16,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              create_valid,
  input logic              create_reject,
  input logic              upd_valid,
  input logic [5:0]        upd_idx,
  input logic              upd_error,
  input logic [63:0]       ctrl_word,
  input logic              task_valid,
  input logic              task_ready,
  input logic [CODE_W-1:0] task_code,
  input logic [3:0]        task_args,
  input logic [DATA_W-1:0] task_handle
);
  // R9
  task_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_valid && !task_ready |=> task_valid && $stable(task_code) &&
                                  $stable(task_args) && $stable(task_handle));

  // R4
  flag_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctrl_word[47:32]) == 32'(ctrl_word[5:0]));

  // R7
  fire_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(task_valid) |-> ctrl_word[5:0] == ctrl_word[11:6]);

  // R5
  dup_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !create_valid && (upd_idx < 6'd16) && ctrl_word[32 + 32'(upd_idx[3:0])]
      |=> upd_error && $stable(ctrl_word));

  // R2
  busy_create_chk: assert property (@(posedge clk) disable iff (!rst_n)
    create_valid && task_valid |=> create_reject);

  // R8
  null_handle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_valid && (task_args == 4'd0) |-> task_handle == '0);
endmodule

bind sync_join_tracker sjt_chk #(.CODE_W(CODE_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .create_valid(create_valid), .create_reject(create_reject),
  .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_error(upd_error), .ctrl_word(ctrl_word),
  .task_valid(task_valid), .task_ready(task_ready), .task_code(task_code),
  .task_args(task_args), .task_handle(task_handle)
);

// File: tb/sync_join_tracker_tb_top.sv
module sync_join_tracker_tb_top;
  logic        clk;
  logic        rst_n;
  logic        create_valid;
  logic [15:0] create_code;
  logic [5:0]  create_args;
  logic [5:0]  create_items;
  logic [63:0] create_handle;
  logic        create_reject;
  logic        upd_valid;
  logic [5:0]  upd_idx;
  logic [63:0] upd_data;
  logic        upd_error;
  logic [3:0]  rd_idx;
  logic [63:0] rd_data;
  logic [63:0] ctrl_word;
  logic        task_valid;
  logic        task_ready;
  logic [15:0] task_code;
  logic [3:0]  task_args;
  logic [63:0] task_handle;

  int n_checks = 0;
  int n_fail   = 0;

  sync_join_tracker dut_i (
    .clk(clk), .rst_n(rst_n),
    .create_valid(create_valid), .create_code(create_code), .create_args(create_args),
    .create_items(create_items), .create_handle(create_handle), .create_reject(create_reject),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_data(upd_data), .upd_error(upd_error),
    .rd_idx(rd_idx), .rd_data(rd_data), .ctrl_word(ctrl_word),
    .task_valid(task_valid), .task_ready(task_ready), .task_code(task_code),
    .task_args(task_args), .task_handle(task_handle)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ctrl(input logic [15:0] code, input logic [15:0] flags,
                                           input logic [5:0] args, input logic [5:0] items,
                                           input logic [5:0] cnt);
    return {code, flags, 2'b00, args, 12'h000, items, cnt};
  endfunction

  function automatic logic [63:0] val_of(input int n, input int ord, input int idx);
    return 64'h5A3C_0000_0000_0000 ^ (64'(n) << 40) ^ (64'(idx) << 8) ^ 64'(ord) ^ (64'(idx*n) << 20);
  endfunction

  // drive for one clock, sample at the following falling edge
  task automatic do_create(input logic [15:0] code, input logic [5:0] args,
                           input logic [5:0] items, input logic [63:0] h);
    create_valid = 1'b1; create_code = code; create_args = args;
    create_items = items; create_handle = h;
    @(negedge clk);
    create_valid = 1'b0;
  endtask

  task automatic do_update(input logic [5:0] idx, input logic [63:0] d);
    upd_valid = 1'b1; upd_idx = idx; upd_data = d;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [63:0] cw_before;
    logic [15:0] flags;
    rst_n = 1'b0; create_valid = 1'b0; upd_valid = 1'b0; task_ready = 1'b0;
    create_code = '0; create_args = '0; create_items = '0; create_handle = '0;
    upd_idx = '0; upd_data = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrl_word == 64'd0, "R1 ctrl_word", ctrl_word, 64'd0);
    check(!task_valid && !create_reject && !upd_error, "R1 outputs",
          {61'd0, task_valid, create_reject, upd_error}, 64'd0);
    // R10 update with nothing open
    do_update(6'd0, 64'h1);
    check(upd_error && ctrl_word == 64'd0, "R10 idle update", {63'd0, upd_error}, 64'd1);

    for (int n = 1; n <= 16; n++) begin
      for (int ord = 0; ord < 3; ord++) begin
        logic [15:0] code;
        logic [5:0]  args;
        logic [63:0] h;
        int half;
        code = 16'(n * 16 + ord + 16'h7100);
        args = 6'((n + ord) % 15);
        h    = 64'hC0DE_0000_0000_0000 | 64'(n * 3 + ord);
        half = (n + 1) / 2;
        do_create(code, args, 6'(n), h);
        // R3 fields loaded, flags and counter cleared
        check(!create_reject && ctrl_word == exp_ctrl(code, 16'd0, args, 6'(n), 6'd0),
              "R3 create", ctrl_word, exp_ctrl(code, 16'd0, args, 6'(n), 6'd0));
        // R2 second setup during collection
        cw_before = ctrl_word;
        do_create(16'hFFFF, 6'd1, 6'd1, 64'd9);
        check(create_reject && ctrl_word == cw_before, "R2 busy create", ctrl_word, cw_before);
        flags = '0;
        for (int p = 0; p < n; p++) begin
          int idx;
          if (ord == 0)      idx = p;
          else if (ord == 1) idx = n - 1 - p;
          else               idx = (p < half) ? 2 * p : 2 * (p - half) + 1;
          if (p > 0 && (p % 3) == 1) begin
            int prev;
            if (ord == 0)      prev = p - 1;
            else if (ord == 1) prev = n - p;
            else               prev = (p - 1 < half) ? 2 * (p - 1) : 2 * (p - 1 - half) + 1;
            cw_before = ctrl_word;
            do_update(6'(prev), 64'hDEAD);
            check(upd_error && ctrl_word == cw_before, "R5 duplicate", ctrl_word, cw_before);
            rd_idx = 4'(prev); #0.1;
            check(rd_data == val_of(n, ord, prev), "R5 slot kept", rd_data, val_of(n, ord, prev));
          end
          if (p == 0) begin
            cw_before = ctrl_word;
            do_update(6'(n), 64'hBAD);
            check(upd_error && ctrl_word == cw_before, "R6 out of range", ctrl_word, cw_before);
          end
          do_update(6'(idx), val_of(n, ord, idx));
          flags[idx] = 1'b1;
          check(!upd_error && ctrl_word == exp_ctrl(code, flags, args, 6'(n), 6'(p + 1)),
                "R4 update", ctrl_word, exp_ctrl(code, flags, args, 6'(n), 6'(p + 1)));
          if (p < n - 1)
            check(!task_valid, "R7 no early fire", {63'd0, task_valid}, 64'd0);
        end
        // R7 record presented
        check(task_valid && task_code == code && task_args == args[3:0], "R7 record",
              {44'd0, task_code, task_args}, {44'd0, code, args[3:0]});
        // R8 handle nulled when no arguments
        check(task_handle == ((args == 0) ? 64'd0 : h), "R8 handle", task_handle,
              (args == 0) ? 64'd0 : h);
        // R2 setup while record pending
        do_create(16'h1234, 6'd1, 6'd2, 64'd5);
        check(create_reject, "R2 pending create", {63'd0, create_reject}, 64'd1);
        // R9 stalled queue
        @(negedge clk);
        check(task_valid && task_code == code, "R9 hold", {48'd0, task_code}, {48'd0, code});
        task_ready = 1'b1;
        @(negedge clk);
        task_ready = 1'b0;
        check(!task_valid, "R9 drop", {63'd0, task_valid}, 64'd0);
        // R4 stored values read back
        for (int i = 0; i < n; i++) begin
          rd_idx = 4'(i); #0.1;
          check(rd_data == val_of(n, ord, i), "R4 readback", rd_data, val_of(n, ord, i));
        end
        // R10 late update after the join fired
        cw_before = ctrl_word;
        do_update(6'd0, 64'hFEED);
        @(negedge clk);
        check(!task_valid && ctrl_word == cw_before, "R10 late update", ctrl_word, cw_before);
        rd_idx = 4'd0; #0.1;
        check(rd_data == val_of(n, ord, 0), "R10 slot kept", rd_data, val_of(n, ord, 0));
      end
    end

    // R2 bad field values from the finished state
    cw_before = ctrl_word;
    do_create(16'h0001, 6'd0, 6'd0, 64'd1);
    check(create_reject && ctrl_word == cw_before, "R2 zero items", ctrl_word, cw_before);
    do_create(16'h0001, 6'd0, 6'd17, 64'd1);
    check(create_reject && ctrl_word == cw_before, "R2 items over", ctrl_word, cw_before);
    do_create(16'h0001, 6'd15, 6'd4, 64'd1);
    check(create_reject && ctrl_word == cw_before, "R2 args over", ctrl_word, cw_before);
    // R3 reserved bits zero with maximum field values
    do_create(16'hFFFF, 6'd14, 6'd16, 64'd7);
    check(ctrl_word[31:30] == 2'b00 && ctrl_word[23:12] == 12'd0 &&
          ctrl_word == exp_ctrl(16'hFFFF, 16'd0, 6'd14, 6'd16, 6'd0),
          "R3 reserved", ctrl_word, exp_ctrl(16'hFFFF, 16'd0, 6'd14, 6'd16, 6'd0));

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule